// File: doc/BRIEF.md
# Nibble RAM Dual-Stack Pointer Unit

This block sits between a small stack-oriented processor and its 256-entry, 4-bit-wide data RAM. It holds an expression stack pointer, a return stack pointer, two index registers and a top-of-stack register that serves as the accumulator. The topmost expression-stack value is kept in that register rather than in RAM, so the expression stack pointer always aims at the second element.

Commands arrive on a 5-bit opcode port. A nibble push or pop moves one value between the top-of-stack register and RAM. A 12-bit return push or pop moves three nibbles, one per cycle, with `busy` raised in between. Pointer loads take their value from `ld_val`. Fetch and store commands move a nibble between RAM and the top-of-stack register through either index register, which is pre-incremented or post-decremented. The block drives the RAM address, write data and write enable. The RAM is read asynchronously through `ram_rdata`.

Top module: `nib_stack_unit`

## Requirements
- R1: After reset all four pointers and the top-of-stack register read zero, and `busy` and `ret_valid` are low.
- R2: Opcode 01h (push) writes the old top-of-stack to address sp+1 in the same cycle. It then increments sp and loads `push_nib` into the top-of-stack register.
- R3: Opcode 02h (pop) reads address sp into the top-of-stack register, then decrements sp.
- R4: Opcode 03h (return push) adds 4 to rp. It writes `ret_in` least significant nibble first to new rp+1, rp+2 and rp+3 in three consecutive cycles, and holds `busy` high for the second and third of those cycles.
- R5: Opcode 04h (return pop) reads rp+1, rp+2 and rp+3 in three consecutive cycles, with `busy` high for the last two. It then subtracts 4 from rp and raises `ret_valid` for one cycle, with `ret_out` = {nibble at rp+3, rp+2, rp+1}.
- R6: While `busy` is high, `cmd` is ignored and no expression-stack or index state changes.
- R7: Opcodes 05h, 06h, 07h and 08h load sp, rp, x and y from `ld_val`. Other opcodes below 10h do nothing.
- R8: Opcodes 1zyph with z=0 (fetch) select y when bit y=1 and x when y=0. Bit p=0 means pre-increment: the index is incremented and the new value is the address. Bit p=1 means post-decrement: the old value is the address and the index is then decremented. The addressed nibble is loaded into the top-of-stack register.
- R9: The same opcodes with z=1 (store) write the top-of-stack value to the addressed location, with the same index update.
- R10: All pointer arithmetic wraps modulo 256 without any indication.
- R11: A return push never writes a nibble whose address has bits [1:0] = 00 when rp is a multiple of 4. There is at most one RAM access per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 5 | Operation code, sampled when not busy |
| push_nib | input | 4 | Nibble pushed onto the expression stack |
| ld_val | input | 8 | Value for pointer loads |
| ret_in | input | 12 | Return address to push |
| ram_rdata | input | 4 | Asynchronous RAM read data |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 4 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| tos_nib | output | 4 | Top-of-stack register |
| busy | output | 1 | Multi-cycle return operation in progress |
| ret_out | output | 12 | Popped return address |
| ret_valid | output | 1 | One-cycle pulse when `ret_out` is valid |

## Verification
Directed sequences come first. They pop from a fresh pointer at zero to force the wrap down to FFh, and push a return entry from FCh so that it wraps to 00h. They also drive a nibble push during `busy` to show that commands are ignored. Random command streams then mix nibble stack traffic, return-stack traffic, loads and all eight index modes. These streams separate a wrong address sequence from a wrong nibble order, and a lost write from a stale top-of-stack value. Every cycle's address, write enable and write data are compared against a bench model, and every later read-back goes through the top-of-stack register or `ret_out`.

// File: rtl/nib_stack_unit.sv
module nib_stack_unit #(
  parameter int AW = 8,
  parameter int DW = 4,
  localparam int RW = 3 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cmd,
  input  logic [DW-1:0] push_nib,
  input  logic [AW-1:0] ld_val,
  input  logic [RW-1:0] ret_in,
  input  logic [DW-1:0] ram_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic [DW-1:0] tos_nib,
  output logic          busy,
  output logic [RW-1:0] ret_out,
  output logic          ret_valid
);
  localparam logic [4:0] C_NOP = 5'h00, C_PUSH = 5'h01, C_POP = 5'h02,
                         C_RPUSH = 5'h03, C_RPOP = 5'h04, C_LDSP = 5'h05,
                         C_LDRP = 5'h06, C_LDX = 5'h07, C_LDY = 5'h08;

  logic [AW-1:0] sp, rp, xr, yr;
  logic [DW-1:0] tos_q;
  logic [1:0]    phase;
  logic          pop_mode;
  logic [RW-1:0] hold;
  logic          rv_q;

  logic [4:0]    c;
  logic          is_idx, idx_store, idx_y, idx_post;
  logic [AW-1:0] idx, idx_nxt, idx_addr;

  assign busy      = (phase != 2'd0);
  assign c         = busy ? C_NOP : cmd;
  assign is_idx    = c[4];
  assign idx_store = c[2];
  assign idx_y     = c[1];
  assign idx_post  = c[0];
  assign idx       = idx_y ? yr : xr;
  assign idx_nxt   = idx_post ? idx - 1'b1 : idx + 1'b1;
  assign idx_addr  = idx_post ? idx : idx + 1'b1;
  assign tos_nib   = tos_q;
  assign ret_out   = hold;
  assign ret_valid = rv_q;

  always_comb begin
    ram_addr  = sp;
    ram_we    = 1'b0;
    ram_wdata = tos_q;
    if (busy) begin
      ram_addr  = rp + AW'(phase) + AW'(1);
      ram_we    = !pop_mode;
      ram_wdata = (phase == 2'd1) ? hold[2*DW-1:DW] : hold[RW-1:2*DW];
    end else if (is_idx) begin
      ram_addr = idx_addr;
      ram_we   = idx_store;
    end else begin
      case (c)
        C_PUSH:  begin ram_addr = sp + 1'b1; ram_we = 1'b1; end
        C_RPUSH: begin ram_addr = rp + AW'(5); ram_we = 1'b1; ram_wdata = ret_in[DW-1:0]; end
        C_RPOP:  ram_addr = rp + AW'(1);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0; rp <= '0; xr <= '0; yr <= '0; tos_q <= '0;
      phase <= 2'd0; pop_mode <= 1'b0; hold <= '0; rv_q <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (busy) begin
        if (pop_mode) begin
          if (phase == 2'd1) hold[2*DW-1:DW] <= ram_rdata;
          else               hold[RW-1:2*DW] <= ram_rdata;
        end
        if (phase == 2'd2) begin
          phase <= 2'd0;
          if (pop_mode) begin
            rp   <= rp - AW'(4);
            rv_q <= 1'b1;
          end
        end else begin
          phase <= phase + 2'd1;
        end
      end else if (is_idx) begin
        if (idx_y) yr <= idx_nxt;
        else       xr <= idx_nxt;
        if (!idx_store) tos_q <= ram_rdata;
      end else begin
        case (c)
          C_PUSH:  begin sp <= sp + 1'b1; tos_q <= push_nib; end
          C_POP:   begin sp <= sp - 1'b1; tos_q <= ram_rdata; end
          C_RPUSH: begin rp <= rp + AW'(4); hold <= ret_in; phase <= 2'd1; pop_mode <= 1'b0; end
          C_RPOP:  begin hold[DW-1:0] <= ram_rdata; phase <= 2'd1; pop_mode <= 1'b1; end
          C_LDSP:  sp <= ld_val;
          C_LDRP:  rp <= ld_val;
          C_LDX:   xr <= ld_val;
          C_LDY:   yr <= ld_val;
          default: ;
        endcase
      end
    end
  end

  p_busy_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |=> !busy);

  p_ret_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ($past(busy) && !busy));

  p_pop_tos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == C_POP) |=> (tos_nib == $past(ram_rdata)));

  p_push_tos_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == C_PUSH) |=> (tos_nib == $past(push_nib)));

  p_rp_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rp != $past(rp)) && !($past(!busy) && $past(cmd) == C_LDRP))
      |-> ((AW'(rp - $past(rp)) == AW'(4)) || (AW'(rp - $past(rp)) == AW'(-4))));

  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sp) && $stable(xr) && $stable(yr) && $stable(tos_nib)));

  p_gap_nibble_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ram_we && rp[1:0] == 2'b00) |-> (ram_addr[1:0] != 2'b00));
endmodule

// File: tb/test_nib_stack_unit.sv
`timescale 1ns/1ps
module test_nib_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  cmd = '0;
  logic [3:0]  push_nib = '0;
  logic [7:0]  ld_val = '0;
  logic [11:0] ret_in = '0;
  logic [3:0]  ram_rdata;
  logic [7:0]  ram_addr;
  logic [3:0]  ram_wdata;
  logic        ram_we;
  logic [3:0]  tos_nib;
  logic        busy;
  logic [11:0] ret_out;
  logic        ret_valid;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [3:0] ram [256];
  logic [3:0] mmem [256];
  logic [7:0] m_sp = 0, m_rp = 0, m_x = 0, m_y = 0;
  logic [3:0] m_tos = 0;

  always #2.5 clk = ~clk;

  nib_stack_unit i_nib_stack_unit (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .push_nib(push_nib), .ld_val(ld_val),
    .ret_in(ret_in), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_we(ram_we), .tos_nib(tos_nib), .busy(busy),
    .ret_out(ret_out), .ret_valid(ret_valid));

  assign ram_rdata = ram[ram_addr];
  always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] idx_addr(input logic [7:0] i, input bit post);
    return post ? i : i + 8'd1;
  endfunction

  function automatic logic [7:0] idx_next(input logic [7:0] i, input bit post);
    return post ? i - 8'd1 : i + 8'd1;
  endfunction

  task automatic op(input logic [4:0] c, input logic [3:0] d,
                    input logic [7:0] l, input logic [11:0] r);
    logic [7:0] a;
    logic [11:0] er;
    @(negedge clk);
    cmd = c; push_nib = d; ld_val = l; ret_in = r;
    #1;
    if (c[4]) begin
      a = idx_addr(c[1] ? m_y : m_x, c[0]);
      chk(ram_addr == a, c[2] ? "R9 store addr" : "R8 fetch addr", ram_addr, a);
      chk(ram_we == c[2], c[2] ? "R9 store we" : "R8 fetch we", ram_we, c[2]);
      if (c[2]) begin
        chk(ram_wdata == m_tos, "R9 store data", ram_wdata, m_tos);
        mmem[a] = m_tos;
      end else m_tos = mmem[a];
      if (c[1]) m_y = idx_next(m_y, c[0]); else m_x = idx_next(m_x, c[0]);
    end else begin
      case (c)
        5'h01: begin
          chk(ram_addr == m_sp + 8'd1 && ram_we && ram_wdata == m_tos,
              "R2 push write", {ram_we, ram_addr, ram_wdata}, {1'b1, m_sp + 8'd1, m_tos});
          m_sp = m_sp + 8'd1; mmem[m_sp] = m_tos; m_tos = d;
        end
        5'h02: begin
          chk(ram_addr == m_sp && !ram_we, "R3 pop addr", ram_addr, m_sp);
          m_tos = mmem[m_sp]; m_sp = m_sp - 8'd1;
        end
        5'h03: begin
          m_rp = m_rp + 8'd4;
          for (int k = 0; k < 3; k++) begin
            if (k > 0) begin
              @(negedge clk);
              cmd = 5'h01; push_nib = ~d;
              #1;
              chk(busy, "R4 busy", busy, 1);
            end
            a = m_rp + 8'(k + 1);
            chk(ram_addr == a && ram_we && ram_wdata == r[4*k +: 4],
                "R4 rpush write", {ram_addr, ram_wdata}, {a, r[4*k +: 4]});
            chk(ram_addr[1:0] != 2'b00 || m_rp[1:0] != 2'b00, "R11 gap nibble", ram_addr, a);
            mmem[a] = r[4*k +: 4];
          end
        end
        5'h04: begin
          er = {mmem[m_rp + 8'd3], mmem[m_rp + 8'd2], mmem[m_rp + 8'd1]};
          for (int k = 0; k < 3; k++) begin
            if (k > 0) begin
              @(negedge clk);
              cmd = 5'h02;
              #1;
              chk(busy, "R5 busy", busy, 1);
            end
            a = m_rp + 8'(k + 1);
            chk(ram_addr == a && !ram_we, "R5 rpop addr", ram_addr, a);
          end
          m_rp = m_rp - 8'd4;
          @(negedge clk);
          cmd = 5'h00;
          #1;
          chk(ret_valid && !busy, "R5 ret_valid", ret_valid, 1);
          chk(ret_out == er, "R5 ret_out", ret_out, er);
        end
        5'h05: m_sp = l;
        5'h06: m_rp = l;
        5'h07: m_x = l;
        5'h08: m_y = l;
        default: chk(!ram_we, "R7 nop no write", ram_we, 0);
      endcase
    end
    @(negedge clk);
    cmd = 5'h00;
    #1;
    chk(tos_nib == m_tos, "R6 R2 R3 R8 tos", tos_nib, m_tos);
    chk(!busy, "R4 busy released", busy, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [4:0] c;
    int sel;
    for (int i = 0; i < 256; i++) begin ram[i] = 4'h0; mmem[i] = 4'h0; end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(tos_nib == 0 && !busy && !ret_valid, "R1 reset outputs", {tos_nib, busy, ret_valid}, 0);
    chk(ram_addr == 0, "R1 reset sp", ram_addr, 0);
    op(5'h02, 0, 0, 0);
    @(negedge clk); #1;
    op(5'h01, 4'h9, 0, 0);
    op(5'h06, 0, 8'hFC, 0);
    op(5'h03, 4'h5, 0, 12'hABC);
    op(5'h08, 0, 8'hFF, 0);
    op(5'h10 | 5'h02, 0, 0, 0);
    op(5'h10 | 5'h02, 0, 0, 0);
    op(5'h04, 0, 0, 0);
    op(5'h07, 0, 8'h00, 0);
    op(5'h14 | 5'h01, 0, 0, 0);
    op(5'h10 | 5'h00, 0, 0, 0);
    op(5'h0C, 0, 0, 0);
    for (int n = 0; n < 400; n++) begin
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: c = 5'h01;
        2:    c = 5'h02;
        3:    c = 5'h03;
        4:    c = 5'h04;
        5:    c = 5'(5 + $urandom_range(0, 3));
        6:    c = 5'($urandom_range(9, 15));
        default: c = 5'h10 | 5'($urandom_range(0, 7));
      endcase
      op(c, 4'($urandom), 8'($urandom), 12'($urandom));
    end
    finish_run();
  end
endmodule